// File: doc/BRIEF.md
# Branch Condition Unit

This block decides whether a conditional branch is taken in a simple 32-bit load/store processor. It then paces the steps that follow the decision. In the evaluate step the control logic raises a load strobe. At the same time it places the tested register's value on the internal bus and presents a 3-bit condition code. At the clock edge the unit stores the verdict in a one-bit condition flag.

In the next step a plain branch drives its target register onto the bus. In that step the program counter load is raised only when the flag is set. Otherwise the program counter keeps the incremented value it received during fetch.

A branch-and-link variant inserts one extra step before the target step. In that extra step the current program counter is written to the link register whatever the verdict. The target load therefore happens one step later. After the target step the unit goes quiet until the next strobe. The flag keeps its value until the next strobe or reset.

Top module: `branch_cond_unit`

## Requirements
- R1: While reset is asserted (active-low, asynchronous), con_o, link_we_o, rb_oe_o and pc_ld_o are all 0.
- R2: On a clock edge with lcon_i high, the flag takes the verdict of cond_sel_i applied to bus_i, and con_o shows it from the next cycle.
- R3: Code 000 always gives a verdict of 0 and code 001 always gives 1. The unused codes 110 and 111 give 0.
- R4: Code 010 gives 1 exactly when every bit of bus_i is 0. Code 011 gives 1 exactly when at least one bit is 1.
- R5: Code 100 gives 1 when bit 31 of bus_i is 0. Code 101 gives 1 when bit 31 is 1.
- R6: While lcon_i is low, con_o keeps its value, whatever cond_sel_i and bus_i do.
- R7: With link_i low at the strobe, the very next cycle is the target step: rb_oe_o is 1 and link_we_o is 0.
- R8: pc_ld_o is 1 only in the target step and only when con_o is 1. In the target step with con_o at 0, pc_ld_o is 0.
- R9: With link_i high at the strobe, the next cycle is the link step, with link_we_o at 1 and rb_oe_o at 0 regardless of the verdict. The cycle after that is the target step.
- R10: After the target step, with no new strobe, link_we_o, rb_oe_o and pc_ld_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lcon_i | input | 1 | Condition load strobe for the evaluate step |
| link_i | input | 1 | Selects the branch-and-link sequence, sampled with lcon_i |
| cond_sel_i | input | 3 | Condition code, sampled with lcon_i |
| bus_i | input | 32 | Internal bus carrying the tested operand |
| con_o | output | 1 | Stored condition flag |
| link_we_o | output | 1 | Link step: write current PC to the link register |
| rb_oe_o | output | 1 | Target step: drive the target register onto the bus |
| pc_ld_o | output | 1 | Load the program counter from the bus |

## Verification
The assertions assume the strobe marks the evaluate step. They also assume that link_i, cond_sel_i and bus_i are valid in the strobe cycle. A strobe raised in the middle of a sequence is taken as a restart, and the properties that follow a link step allow for it. The stimulus raises the strobe for one cycle only. It then lets each sequence run to its idle cycle before the next strobe. It scrambles the code and the bus after the strobe so that holding the flag is tested against changing inputs.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  typedef enum logic [2:0] {
    CS_NEVER   = 3'b000,
    CS_ALWAYS  = 3'b001,
    CS_ZERO    = 3'b010,
    CS_NONZERO = 3'b011,
    CS_NONNEG  = 3'b100,
    CS_NEG     = 3'b101,
    CS_RSV6    = 3'b110,
    CS_RSV7    = 3'b111
  } cond_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LINK = 2'd1,
    ST_TGT  = 2'd2
  } step_e;
endpackage

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [2:0]        sel_i,
  input  logic [DATA_W-1:0] opd_i,
  output logic              met_o
);
  import bcu_pkg::*;
  localparam int NUM_LANES = DATA_W / LANE_W;

  logic [NUM_LANES-1:0] lane_zero;
  logic                 is_zero;
  logic                 is_neg;

  // per-lane NOR, then AND across lanes keeps the zero test shallow
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign lane_zero[g] = ~|opd_i[g*LANE_W +: LANE_W];
  end

  assign is_zero = &lane_zero;
  assign is_neg  = opd_i[DATA_W-1];

  always_comb begin
    unique case (cond_sel_e'(sel_i))
      CS_NEVER:   met_o = 1'b0;
      CS_ALWAYS:  met_o = 1'b1;
      CS_ZERO:    met_o = is_zero;
      CS_NONZERO: met_o = ~is_zero;
      CS_NONNEG:  met_o = ~is_neg;
      CS_NEG:     met_o = is_neg;
      default:    met_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcu_con_reg.sv
module bcu_con_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= 1'b0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/bcu_step_seq.sv
module bcu_step_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic link_i,
  output logic link_step_o,
  output logic tgt_step_o
);
  import bcu_pkg::*;
  step_e step_q, step_d;

  always_comb begin
    step_d = ST_IDLE;
    if (start_i)                step_d = link_i ? ST_LINK : ST_TGT;
    else if (step_q == ST_LINK) step_d = ST_TGT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= ST_IDLE;
    else         step_q <= step_d;
  end

  assign link_step_o = (step_q == ST_LINK);
  assign tgt_step_o  = (step_q == ST_TGT);
endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lcon_i,
  input  logic              link_i,
  input  logic [2:0]        cond_sel_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              con_o,
  output logic              link_we_o,
  output logic              rb_oe_o,
  output logic              pc_ld_o
);
  logic met;
  logic tgt_step;

  bcu_cond_eval #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_eval (
    .sel_i (cond_sel_i),
    .opd_i (bus_i),
    .met_o (met)
  );

  bcu_con_reg i_con (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (lcon_i),
    .d_i    (met),
    .q_o    (con_o)
  );

  bcu_step_seq i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (lcon_i),
    .link_i      (link_i),
    .link_step_o (link_we_o),
    .tgt_step_o  (tgt_step)
  );

  assign rb_oe_o = tgt_step;
  assign pc_ld_o = tgt_step & con_o;
endmodule

// File: rtl/bcu_checker.sv
module bcu_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lcon_i,
  input logic              link_i,
  input logic [2:0]        cond_sel_i,
  input logic [DATA_W-1:0] bus_i,
  input logic              con_o,
  input logic              link_we_o,
  input logic              rb_oe_o,
  input logic              pc_ld_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !con_o && !link_we_o && !rb_oe_o && !pc_ld_o);

  assert_always_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcon_i && cond_sel_i == 3'b001 |=> con_o);

  assert_never_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcon_i && (cond_sel_i == 3'b000 || cond_sel_i[2:1] == 2'b11) |=> !con_o);

  assert_zero_test_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcon_i && cond_sel_i == 3'b010 |=> con_o == ($past(bus_i) == '0));

  assert_sign_test_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcon_i && cond_sel_i == 3'b101 |=> con_o == $past(bus_i[DATA_W-1]));

  assert_con_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lcon_i |=> $stable(con_o));

  assert_plain_target_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcon_i && !link_i |=> rb_oe_o && !link_we_o);

  assert_pc_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_ld_o |-> con_o && rb_oe_o);

  assert_link_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcon_i && link_i |=> link_we_o && !rb_oe_o);

  assert_link_then_target_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o && !lcon_i |=> rb_oe_o);

  assert_steps_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({link_we_o, rb_oe_o}));

  assert_idle_after_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_oe_o && !lcon_i |=> !rb_oe_o && !link_we_o && !pc_ld_o);
endmodule

bind branch_cond_unit bcu_checker #(.DATA_W(DATA_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lcon_i     (lcon_i),
  .link_i     (link_i),
  .cond_sel_i (cond_sel_i),
  .bus_i      (bus_i),
  .con_o      (con_o),
  .link_we_o  (link_we_o),
  .rb_oe_o    (rb_oe_o),
  .pc_ld_o    (pc_ld_o)
);

// File: tb/test_branch_cond_unit.sv
module test_branch_cond_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        lcon_i = 1'b0;
  logic        link_i = 1'b0;
  logic [2:0]  cond_sel_i = 3'b000;
  logic [31:0] bus_i = '0;
  logic        con_o, link_we_o, rb_oe_o, pc_ld_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  branch_cond_unit i_branch_cond_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .lcon_i(lcon_i), .link_i(link_i),
    .cond_sel_i(cond_sel_i), .bus_i(bus_i), .con_o(con_o),
    .link_we_o(link_we_o), .rb_oe_o(rb_oe_o), .pc_ld_o(pc_ld_o)
  );

  // {link, sel[2:0], bus[31:0], expected verdict}
  localparam logic [36:0] VEC [16] = '{
    {1'b0, 3'b000, 32'h0000_0000, 1'b0},
    {1'b0, 3'b001, 32'hFFFF_FFFF, 1'b1},
    {1'b0, 3'b010, 32'h0000_0000, 1'b1},
    {1'b0, 3'b010, 32'h0000_0001, 1'b0},
    {1'b0, 3'b011, 32'h8000_0000, 1'b1},
    {1'b0, 3'b011, 32'h0000_0000, 1'b0},
    {1'b0, 3'b100, 32'h7FFF_FFFF, 1'b1},
    {1'b0, 3'b100, 32'h8000_0000, 1'b0},
    {1'b0, 3'b101, 32'h8000_0000, 1'b1},
    {1'b0, 3'b101, 32'h0000_0000, 1'b0},
    {1'b0, 3'b110, 32'h0000_0000, 1'b0},
    {1'b0, 3'b111, 32'hFFFF_FFFF, 1'b0},
    {1'b1, 3'b010, 32'h0000_0000, 1'b1},
    {1'b1, 3'b010, 32'h0000_1000, 1'b0},
    {1'b1, 3'b001, 32'h1234_5678, 1'b1},
    {1'b1, 3'b000, 32'h0000_0000, 1'b0}
  };

  function automatic string sel_req(input logic [2:0] s);
    case (s)
      3'b010, 3'b011: return "R4";
      3'b100, 3'b101: return "R5";
      default:        return "R3";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic run_branch(input logic lnk, input logic [2:0] sel,
                            input logic [31:0] opd, input logic exp);
    @(negedge clk_i);
    lcon_i = 1'b1; link_i = lnk; cond_sel_i = sel; bus_i = opd;
    @(negedge clk_i);
    lcon_i = 1'b0; link_i = ~lnk; cond_sel_i = ~sel; bus_i = ~opd;
    chk(sel_req(sel), "verdict", con_o, exp);
    chk("R2", "flag loaded", con_o, exp);
    if (lnk) begin
      chk("R9", "link_we in link step", link_we_o, 1'b1);
      chk("R9", "rb_oe low in link step", rb_oe_o, 1'b0);
      chk("R8", "pc_ld low in link step", pc_ld_o, 1'b0);
      @(negedge clk_i);
      bus_i = opd ^ 32'h5A5A_5A5A;
    end else begin
      chk("R7", "link_we low", link_we_o, 1'b0);
    end
    chk(lnk ? "R9" : "R7", "rb_oe in target step", rb_oe_o, 1'b1);
    chk("R8", "pc_ld gated by flag", pc_ld_o, exp);
    @(negedge clk_i);
    chk("R10", "rb_oe idle", rb_oe_o, 1'b0);
    chk("R10", "link_we idle", link_we_o, 1'b0);
    chk("R10", "pc_ld idle", pc_ld_o, 1'b0);
    chk("R6", "flag held", con_o, exp);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    lcon_i = 1'b1; cond_sel_i = 3'b001;
    repeat (3) @(negedge clk_i);
    chk("R1", "con in reset", con_o, 1'b0);
    chk("R1", "link_we in reset", link_we_o, 1'b0);
    chk("R1", "rb_oe in reset", rb_oe_o, 1'b0);
    chk("R1", "pc_ld in reset", pc_ld_o, 1'b0);
    lcon_i = 1'b0;
    rst_ni = 1'b1;

    for (int i = 0; i < 16; i++)
      run_branch(VEC[i][36], VEC[i][35:33], VEC[i][32:1], VEC[i][0]);

    // hold under scrambled inputs, starting from a set flag
    run_branch(1'b0, 3'b001, 32'h0, 1'b1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i);
      cond_sel_i = 3'(k); bus_i = 32'h1 << k;
      chk("R6", "flag held, no strobe", con_o, 1'b1);
      chk("R10", "no step without strobe", rb_oe_o | link_we_o | pc_ld_o, 1'b0);
    end

    // link step runs even with a clear flag; no PC load in target step
    run_branch(1'b1, 3'b011, 32'h0, 1'b0);

    // async reset in the middle of a link sequence
    run_branch(1'b0, 3'b001, 32'h0, 1'b1);
    @(negedge clk_i);
    lcon_i = 1'b1; link_i = 1'b1; cond_sel_i = 3'b001;
    @(negedge clk_i);
    lcon_i = 1'b0;
    #3 rst_ni = 1'b0;
    #2;
    chk("R1", "con cleared by async reset", con_o, 1'b0);
    chk("R1", "link_we cleared by async reset", link_we_o, 1'b0);
    @(negedge clk_i);
    chk("R1", "rb_oe held low in reset", rb_oe_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10", "idle after reset", rb_oe_o | link_we_o | pc_ld_o, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule